// File: doc/BRIEF.md
# 4x4 Matrix Keypad Scanner

This block scans a sixteen-key matrix keypad wired as four row lines and four column lines. It pulls one row low at a time, leaves the other three high, and reads the columns with pull-up semantics, so a column that reads low during a row's turn marks the key at that crossing as pressed. The column lines cross a two-flop synchronizer. Each row dwells for a parameterized number of cycles before its columns are sampled. A full pass over the four rows yields a sixteen-bit snapshot of the keys.

Snapshots feed a debouncer that counts whole scans. A key is accepted once it has been the first key found in scan order on a parameterized number of consecutive scans. It is released once it has been absent for the same number of consecutive scans. An accepted key raises a one-cycle pulse and a level that stays high until release. Its 4-bit code is shown on the code output and as a hex digit pattern for a seven-segment display. While a key is held, every other key is ignored.

Top module: `keypad_scanner`

## Requirements
- R1: While rst_ni is low, rows_o is 4'b1110, key_valid_o and key_held_o are 0, key_code_o is 0 and seg_o shows the digit 0 (7'h3F).
- R2: In every cycle exactly one bit of rows_o is 0 and the other three are 1.
- R3: The low row steps through rows_o[0], [1], [2], [3] and back to [0], and each row stays low for exactly SETTLE_CYC cycles.
- R4: A key at row r (the row on rows_o[r]) and column c (cols_i[c] reads 0 while that row is low) is reported with key_code_o = 4*r + c.
- R5: seg_o is the hex digit pattern of key_code_o, bit 0 = segment a through bit 6 = segment g, active high: 0..F map to 3F,06,5B,4F,66,6D,7D,07,7F,6F,77,7C,39,5E,79,71.
- R6: A press is accepted only after DEB_SCANS consecutive full scans see it. A press shorter than one scan period is never reported.
- R7: A held key is released only after DEB_SCANS consecutive full scans without it. A shorter gap leaves key_held_o high and raises no new pulse.
- R8: Each accepted press gives exactly one key_valid_o pulse of one cycle. key_held_o rises with that pulse and stays high until release.
- R9: When several keys are down together, the one with the lowest code (first in row-major scan order) is reported.
- R10: While a key is held, pressing other keys changes neither key_code_o nor key_held_o and gives no pulse. After release, a key still down is accepted as a fresh press.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| cols_i | input | 4 | Column lines, low = pressed at the driven row |
| rows_o | output | 4 | Row lines, one driven low at a time |
| key_code_o | output | 4 | Code of the reported key |
| seg_o | output | 7 | Seven-segment pattern of key_code_o, bit 0 = a |
| key_valid_o | output | 1 | One-cycle pulse on a new accepted press |
| key_held_o | output | 1 | High while the accepted key is held |

## Verification
One scan takes 4*SETTLE_CYC cycles. A press is accepted between DEB_SCANS-1 and DEB_SCANS+1 scan periods after it is applied, plus the synchronizer's two cycles, and a release follows the same window. The bench therefore checks that nothing has changed half a scan after a stimulus, and checks the result once DEB_SCANS+2 scan periods have passed, where the outcome is fixed whatever the scan phase was. Pulses are counted over each window, so a missing or doubled key_valid_o pulse is caught. The row sequence and the dwell time are checked cycle by cycle at the falling edge.

// File: rtl/kp_pkg.sv
package kp_pkg;
  localparam int ROWS   = 4;
  localparam int COLS   = 4;
  localparam int KEYS   = ROWS * COLS;
  localparam int CODE_W = $clog2(KEYS);
  localparam int ROW_W  = $clog2(ROWS);

  // bit 0 = segment a ... bit 6 = segment g, active high
  function automatic logic [6:0] hex_seg(input logic [3:0] v);
    case (v)
      4'h0: hex_seg = 7'h3F;
      4'h1: hex_seg = 7'h06;
      4'h2: hex_seg = 7'h5B;
      4'h3: hex_seg = 7'h4F;
      4'h4: hex_seg = 7'h66;
      4'h5: hex_seg = 7'h6D;
      4'h6: hex_seg = 7'h7D;
      4'h7: hex_seg = 7'h07;
      4'h8: hex_seg = 7'h7F;
      4'h9: hex_seg = 7'h6F;
      4'hA: hex_seg = 7'h77;
      4'hB: hex_seg = 7'h7C;
      4'hC: hex_seg = 7'h39;
      4'hD: hex_seg = 7'h5E;
      4'hE: hex_seg = 7'h79;
      default: hex_seg = 7'h71;
    endcase
  endfunction
endpackage

// File: rtl/kp_sync.sv
module kp_sync #(
  parameter int W = 4
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic [W-1:0] d_i,
  output logic [W-1:0] q_o
);
  logic [W-1:0] s1_q, s2_q;

  // idle level is high (not pressed)
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      s1_q <= '1;
      s2_q <= '1;
    end else begin
      s1_q <= d_i;
      s2_q <= s1_q;
    end
  end

  assign q_o = s2_q;
endmodule

// File: rtl/kp_row_scan.sv
module kp_row_scan
  import kp_pkg::*;
#(
  parameter int SETTLE_CYC = 4
) (
  input  logic            clk_i,
  input  logic            rst_ni,
  input  logic [COLS-1:0] cols_sync_i,
  output logic [ROWS-1:0] rows_o,
  output logic            scan_done_o,
  output logic [KEYS-1:0] scan_map_o
);
  localparam int CNT_W = (SETTLE_CYC > 1) ? $clog2(SETTLE_CYC) : 1;
  localparam logic [CNT_W-1:0] CNT_LAST = CNT_W'(SETTLE_CYC - 1);
  localparam logic [ROW_W-1:0] ROW_LAST = ROW_W'(ROWS - 1);

  logic [ROW_W-1:0] row_q;
  logic [CNT_W-1:0] cnt_q;
  logic [KEYS-1:0]  acc_q, acc_d, map_q;
  logic             done_q;
  logic             sample;

  assign sample = (cnt_q == CNT_LAST);

  // merge the current row's columns into the snapshot
  always_comb begin
    acc_d = acc_q;
    for (int c = 0; c < COLS; c++) begin
      acc_d[int'(row_q) * COLS + c] = ~cols_sync_i[c];
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      row_q  <= '0;
      cnt_q  <= '0;
      acc_q  <= '0;
      map_q  <= '0;
      done_q <= 1'b0;
    end else begin
      done_q <= 1'b0;
      if (sample) begin
        cnt_q <= '0;
        if (row_q == ROW_LAST) begin
          row_q  <= '0;
          acc_q  <= '0;
          map_q  <= acc_d;
          done_q <= 1'b1;
        end else begin
          row_q <= row_q + 1'b1;
          acc_q <= acc_d;
        end
      end else begin
        cnt_q <= cnt_q + 1'b1;
      end
    end
  end

  for (genvar r = 0; r < ROWS; r++) begin : g_row
    assign rows_o[r] = (row_q != ROW_W'(r));
  end

  assign scan_done_o = done_q;
  assign scan_map_o  = map_q;

  // R2
  one_row_low_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $countones(~rows_o) == 1);

  // R3
  row_step_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (sample && row_q != ROW_LAST) |=> (row_q == $past(row_q) + 1'b1));

  // R3
  row_dwell_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !sample |=> $stable(rows_o));

  // R3
  scan_wrap_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    scan_done_o |-> (rows_o[0] == 1'b0 && $past(rows_o[ROWS-1]) == 1'b0));
endmodule

// File: rtl/kp_debounce.sv
module kp_debounce
  import kp_pkg::*;
#(
  parameter int DEB_SCANS = 2
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              scan_done_i,
  input  logic [KEYS-1:0]   scan_map_i,
  output logic [CODE_W-1:0] code_o,
  output logic              valid_o,
  output logic              held_o
);
  localparam int DC_W = $clog2(DEB_SCANS + 1);
  localparam logic [DC_W-1:0] DC_MAX = DC_W'(DEB_SCANS);

  logic              hit;
  logic [CODE_W-1:0] first;
  logic [CODE_W-1:0] cand_q, code_q;
  logic [DC_W-1:0]   cnt_q, cnt_nxt, cnt_inc;
  logic              held_q, valid_q, held_key;

  // lowest index wins: row-major scan order
  always_comb begin
    hit   = |scan_map_i;
    first = '0;
    for (int k = KEYS - 1; k >= 0; k--) begin
      if (scan_map_i[k]) first = CODE_W'(k);
    end
  end

  assign held_key = scan_map_i[code_q];
  assign cnt_inc  = DC_W'(cnt_q + 1'b1);

  always_comb begin
    if (!hit)                              cnt_nxt = '0;
    else if (first == cand_q && cnt_q != 0) cnt_nxt = cnt_inc;
    else                                   cnt_nxt = DC_W'(1);
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cand_q  <= '0;
      code_q  <= '0;
      cnt_q   <= '0;
      held_q  <= 1'b0;
      valid_q <= 1'b0;
    end else begin
      valid_q <= 1'b0;
      if (scan_done_i) begin
        if (!held_q) begin
          if (cnt_nxt == DC_MAX) begin
            held_q  <= 1'b1;
            valid_q <= 1'b1;
            code_q  <= first;
            cnt_q   <= '0;
          end else begin
            cnt_q  <= cnt_nxt;
            cand_q <= first;
          end
        end else if (held_key) begin
          cnt_q <= '0;
        end else if (cnt_inc == DC_MAX) begin
          held_q <= 1'b0;
          cnt_q  <= '0;
        end else begin
          cnt_q <= cnt_inc;
        end
      end
    end
  end

  assign code_o  = code_q;
  assign valid_o = valid_q;
  assign held_o  = held_q;

  // R8
  valid_pulse_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    valid_q |=> !valid_q);

  // R8
  held_rise_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(held_q) |-> valid_q);

  // R6
  valid_on_scan_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    valid_q |-> $past(scan_done_i));

  // R10
  code_stable_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (held_q && !valid_q) |-> $stable(code_q));

  // R7
  release_on_scan_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $fell(held_q) |-> $past(scan_done_i && !held_key));
endmodule

// File: rtl/kp_seg_decode.sv
module kp_seg_decode
  import kp_pkg::*;
(
  input  logic [CODE_W-1:0] code_i,
  output logic [6:0]        seg_o
);
  assign seg_o = hex_seg(code_i);

  // R5
  always_comb begin
    seg_nonblank_chk: assert (seg_o != 7'h00);
  end
endmodule

// File: rtl/keypad_scanner.sv
module keypad_scanner
  import kp_pkg::*;
#(
  parameter int SETTLE_CYC = 4,
  parameter int DEB_SCANS  = 2
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic [COLS-1:0]   cols_i,
  output logic [ROWS-1:0]   rows_o,
  output logic [CODE_W-1:0] key_code_o,
  output logic [6:0]        seg_o,
  output logic              key_valid_o,
  output logic              key_held_o
);
  logic [COLS-1:0] cols_sync;
  logic            scan_done;
  logic [KEYS-1:0] scan_map;

  kp_sync #(.W(COLS)) u_sync (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .d_i    (cols_i),
    .q_o    (cols_sync)
  );

  kp_row_scan #(.SETTLE_CYC(SETTLE_CYC)) u_scan (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .cols_sync_i (cols_sync),
    .rows_o      (rows_o),
    .scan_done_o (scan_done),
    .scan_map_o  (scan_map)
  );

  kp_debounce #(.DEB_SCANS(DEB_SCANS)) u_deb (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .scan_done_i (scan_done),
    .scan_map_i  (scan_map),
    .code_o      (key_code_o),
    .valid_o     (key_valid_o),
    .held_o      (key_held_o)
  );

  kp_seg_decode u_seg (
    .code_i (key_code_o),
    .seg_o  (seg_o)
  );

  // R8
  valid_implies_held_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    key_valid_o |-> key_held_o);
endmodule

// File: tb/keypad_scanner_bench.sv
`timescale 1ns/1ps
module keypad_scanner_bench;
  localparam int SETTLE = 4;
  localparam int DEB    = 2;
  localparam int SCAN   = 4 * SETTLE;
  localparam int WAIT   = (DEB + 2) * SCAN;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic [3:0] cols;
  logic [3:0] rows;
  logic [3:0] code;
  logic [6:0] seg;
  logic       valid, held;
  logic [15:0] keys = '0;

  int checks = 0;
  int fails  = 0;
  int vcount = 0;
  bit finished = 1'b0;

  always #2 clk = ~clk;

  keypad_scanner #(.SETTLE_CYC(SETTLE), .DEB_SCANS(DEB)) u_keypad_scanner (
    .clk_i       (clk),
    .rst_ni      (rst_n),
    .cols_i      (cols),
    .rows_o      (rows),
    .key_code_o  (code),
    .seg_o       (seg),
    .key_valid_o (valid),
    .key_held_o  (held)
  );

  // keypad model: pull-up columns, pressed key shorts its column to a low row
  always_comb begin
    cols = 4'hF;
    for (int r = 0; r < 4; r++)
      for (int c = 0; c < 4; c++)
        if (!rows[r] && keys[r*4+c]) cols[c] = 1'b0;
  end

  always @(posedge clk) if (rst_n && valid) vcount++;

  function automatic int exp_seg(input int v);
    case (v)
      0: return 'h3F;  1: return 'h06;  2: return 'h5B;  3: return 'h4F;
      4: return 'h66;  5: return 'h6D;  6: return 'h7D;  7: return 'h07;
      8: return 'h7F;  9: return 'h6F; 10: return 'h77; 11: return 'h7C;
      12: return 'h39; 13: return 'h5E; 14: return 'h79; default: return 'h71;
    endcase
  endfunction

  task automatic chk(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic cyc(input int n);
    repeat (n) @(negedge clk);
  endtask

  function automatic int row_idx(input logic [3:0] r);
    for (int i = 0; i < 4; i++) if (!r[i]) return i;
    return -1;
  endfunction

  initial begin
    repeat (200000) @(posedge clk);
    if (!finished) begin
      fails++;
      checks++;
      $display("FAIL watchdog: actual 1 expected 0");
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end

  initial begin
    int v0;
    cyc(3);
    // R1 reset state
    chk("R1 rows", int'(rows), 'hE);
    chk("R1 valid", int'(valid), 0);
    chk("R1 held", int'(held), 0);
    chk("R1 code", int'(code), 0);
    chk("R1 seg", int'(seg), 'h3F);
    rst_n = 1'b1;

    // R2 / R3 row sequence and dwell
    begin
      int prev, dwell, bad_hot, bad_ord;
      bad_hot = 0; bad_ord = 0;
      while (rows != 4'b1101) @(negedge clk);
      prev = 1; dwell = 0;
      for (int i = 0; i < 4 * SCAN; i++) begin
        @(negedge clk);
        if ($countones(~rows) != 1) bad_hot++;
        if (row_idx(rows) == prev) dwell++;
        else begin
          if (row_idx(rows) != (prev + 1) % 4 || dwell + 1 != SETTLE) bad_ord++;
          prev = row_idx(rows);
          dwell = 0;
        end
      end
      chk("R2 one row low", bad_hot, 0);
      chk("R3 order and dwell", bad_ord, 0);
    end

    // R4 R5 R6 R7 R8 sweep every key
    for (int k = 0; k < 16; k++) begin
      v0 = vcount;
      keys = 16'(1) << k;
      cyc(SCAN / 2);
      chk("R6 not yet accepted", int'(held), 0);
      cyc(WAIT);
      chk("R8 held", int'(held), 1);
      chk("R4 code", int'(code), k);
      chk("R5 seg", int'(seg), exp_seg(k));
      chk("R8 one pulse", vcount - v0, 1);
      keys = '0;
      cyc(SCAN / 2);
      chk("R7 not yet released", int'(held), 1);
      cyc(WAIT);
      chk("R7 released", int'(held), 0);
      chk("R8 no extra pulse", vcount - v0, 1);
    end

    // R6 short press ignored
    v0 = vcount;
    keys = 16'(1) << 7;
    cyc(6);
    keys = '0;
    cyc(WAIT);
    chk("R6 glitch held", int'(held), 0);
    chk("R6 glitch pulse", vcount - v0, 0);

    // R7 short release gap ignored
    v0 = vcount;
    keys = 16'(1) << 3;
    cyc(WAIT);
    keys = '0;
    cyc(6);
    keys = 16'(1) << 3;
    cyc(WAIT);
    chk("R7 gap held", int'(held), 1);
    chk("R7 gap code", int'(code), 3);
    chk("R7 gap pulse", vcount - v0, 1);
    keys = '0;
    cyc(WAIT);

    // R9 same-row pair
    v0 = vcount;
    keys = (16'(1) << 14) | (16'(1) << 12);
    cyc(WAIT);
    chk("R9 same row", int'(code), 12);
    keys = '0;
    cyc(WAIT);

    // R9 / R10 across rows, then lock-out and re-acceptance
    v0 = vcount;
    keys = (16'(1) << 9) | (16'(1) << 5);
    cyc(WAIT);
    chk("R9 first found", int'(code), 5);
    chk("R9 pulse", vcount - v0, 1);
    keys = keys | 16'(1);
    cyc(WAIT);
    chk("R10 code kept", int'(code), 5);
    chk("R10 held kept", int'(held), 1);
    chk("R10 no pulse", vcount - v0, 1);
    keys = keys & ~(16'(1) << 5);
    cyc(2 * WAIT);
    chk("R10 next key", int'(code), 0);
    chk("R10 next seg", int'(seg), exp_seg(0));
    chk("R10 next pulse", vcount - v0, 2);
    keys = '0;
    cyc(WAIT);
    chk("R7 final release", int'(held), 0);

    finished = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule